// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block sits on the memory side of a four-bank DDR SDRAM interface. On every rising clock edge it samples clock-enable, chip-select, the three command strobes, the bank select and the address bus. It turns them into at most one decoded command per cycle and keeps, for each bank, whether a row is open and which row it is. It also keeps the burst-length and CAS-latency fields of the mode register and tracks whether the device is active, powered down or in self-refresh.

The command pins form a plain control interface, not a stream. Each decoded command is reported by a single-cycle strobe in the cycle after the edge that sampled it. There is no back-pressure: the block can never refuse to watch the pins, so no ready signal exists. A command that breaks the open/closed protocol is not passed on. Instead it raises a one-cycle error flag.

A10 has two roles. On a read or write it asks for the addressed bank to be closed once the burst ends. On a precharge it selects every bank at once, and the bank select is then ignored.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset all banks are closed, no strobe or error is raised, the power state is active (code 0), the burst-length field is 1 and the CAS-latency field is 2.
- R2: While cke and a low cs_n are sampled together, {ras_n,cas_n,we_n} decodes as 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode set, reported on cmd_code as 0, 1, 2, 3, 4, 5 and 6. The code 110 is treated as a no-op. cmd_valid is high for exactly the one cycle after the sampling edge, and never for a no-op.
- R3: A high cs_n blocks any new command, but a countdown already running toward an automatic bank close still completes.
- R4: An activate opens the selected bank, stores the 12-bit row from addr, and reports that row on cmd_addr and the bank on cmd_bank.
- R5: A read or write reports the 9-bit column addr[8:0] zero-extended on cmd_addr and addr[10] on cmd_ap. With addr[10] low the bank stays open.
- R6: A precharge with addr[10] low closes only the bank selected by ba, and reports cmd_ap 0.
- R7: A precharge with addr[10] high closes all four banks, reports cmd_ap 1, and reports cmd_bank 0 whatever ba was.
- R8: A read or write to a closed bank, or an activate to an open bank, raises proto_err for one cycle, gives no cmd_valid, and leaves every bank's state and row unchanged.
- R9: A mode set stores addr[2:0] as the burst-length code and addr[6:4] as the CAS-latency code. A read or write with addr[10] high closes its bank at the Nth rising edge after the command edge. N is 1, 2 or 4 for burst-length codes 1, 2 and 3, and any other code counts as 1.
- R10: While an automatic close is pending, a read or write to that same bank is a protocol error. An accepted read or write to another bank cuts the earlier burst short and closes the pending bank at that edge.
- R11: Sampling cke low decodes nothing. From the active state it enters power-down (code 1), or self-refresh (code 2) if a refresh with cs_n low is sampled at that same edge. The state then holds while cke stays low. Sampling cke high returns to active at that edge and decodes the command sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low stops decoding and selects a low-power state |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column or mode value; bit 10 is the close/all flag |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 3 | Decoded command code (R2) |
| cmd_bank | output | 2 | Target bank of the command |
| cmd_addr | output | 12 | Row, zero-extended column, or mode value |
| cmd_ap | output | 1 | Auto-close request (read/write) or all-bank flag (precharge) |
| proto_err | output | 1 | One-cycle flag for a rejected command |
| pwr_state | output | 2 | 0 active, 1 power-down, 2 self-refresh |
| bank_open | output | 4 | Per-bank open flag |
| bank_rows | output | 48 | Open row per bank, bank i in bits [12i+11:12i] |
| mode_bl | output | 3 | Stored burst-length code |
| mode_cl | output | 3 | Stored CAS-latency code |

## Verification
The bench targets the double role of A10. A design that confused the two roles would close all banks on a read, or honour ba on an all-bank precharge. The bench times the automatic close for every burst-length code, including an unsupported one. A design with an off-by-one countdown closes the bank a cycle early or late, and a design that ignores the stored length closes on the wrong edge. It also probes a command issued while chip-select is high in the middle of a countdown: a design that gated the timer with chip-select would leave the bank open. Finally, it walks through power-down and self-refresh entry and exit. In particular, a refresh sampled while already powered down must not turn into self-refresh.

// File: rtl/ddrcmd_pkg.sv
package ddrcmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_DOWN   = 2'd1,
    PWR_SELF   = 2'd2
  } pwr_e;

  // clock cycles a burst occupies for a burst-length code (two beats per cycle)
  function automatic logic [2:0] burst_cycles(input logic [2:0] code);
    case (code)
      3'd2:    burst_cycles = 3'd2;
      3'd3:    burst_cycles = 3'd4;
      default: burst_cycles = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/ddrcmd_decode.sv
module ddrcmd_decode
  import ddrcmd_pkg::*;
(
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    case ({ras_n, cas_n, we_n})
      3'b011:  cmd = CMD_ACT;
      3'b101:  cmd = CMD_RD;
      3'b100:  cmd = CMD_WR;
      3'b010:  cmd = CMD_PRE;
      3'b001:  cmd = CMD_REF;
      3'b000:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddrcmd_bank.sv
module ddrcmd_bank #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (open_req) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end else if (close_req) begin
      is_open <= 1'b0;
    end
  end
endmodule

// File: rtl/ddrcmd_burst.sv
module ddrcmd_burst #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_ap,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              cancel_all,
  input  logic              cancel_one,
  input  logic [BANK_W-1:0] cancel_bank,
  output logic              pend,
  output logic [BANK_W-1:0] pend_bank,
  output logic              close_now
);
  logic [CNT_W-1:0] cnt;

  // pending bank closes on its last cycle, or early when a new burst cuts it short
  assign close_now = pend && (start || cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      pend      <= 1'b0;
      pend_bank <= '0;
    end else if (start) begin
      cnt       <= start_len;
      pend      <= start_ap;
      pend_bank <= start_bank;
    end else begin
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1) || cancel_all || (cancel_one && cancel_bank == pend_bank))
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ddrcmd_power.sv
module ddrcmd_power
  import ddrcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic ref_seen,
  output pwr_e state
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  state <= PWR_ACTIVE;
    else if (cke)                state <= PWR_ACTIVE;
    else if (state == PWR_ACTIVE) state <= ref_seen ? PWR_SELF : PWR_DOWN;
  end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddrcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int BL_LSB    = 0,
  parameter int CL_LSB    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       cmd_valid,
  output logic [2:0]                 cmd_code,
  output logic [BANK_W-1:0]          cmd_bank,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic                       cmd_ap,
  output logic                       proto_err,
  output logic [1:0]                 pwr_state,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] bank_rows,
  output logic [2:0]                 mode_bl,
  output logic [2:0]                 mode_cl
);
  cmd_e pin_cmd, cur;
  pwr_e pwr;
  logic dec_en, is_rw, is_act, is_pre, is_mrs, err, accept;
  logic pre_all, pre_one, rw_go;
  logic pend, close_now;
  logic [BANK_W-1:0] pend_bank;

  ddrcmd_decode u_dec (.ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(pin_cmd));

  assign dec_en  = cke && !cs_n;
  assign cur     = dec_en ? pin_cmd : CMD_NOP;
  assign is_rw   = (cur == CMD_RD) || (cur == CMD_WR);
  assign is_act  = (cur == CMD_ACT);
  assign is_pre  = (cur == CMD_PRE);
  assign is_mrs  = (cur == CMD_MRS);
  assign err     = (is_rw && (!bank_open[ba] || (pend && pend_bank == ba)))
                || (is_act && bank_open[ba]);
  assign accept  = (cur != CMD_NOP) && !err;
  assign pre_all = accept && is_pre && addr[AP_BIT];
  assign pre_one = accept && is_pre && !addr[AP_BIT];
  assign rw_go   = accept && is_rw;

  ddrcmd_burst #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .start(rw_go), .start_ap(addr[AP_BIT]), .start_bank(ba),
    .start_len(burst_cycles(mode_bl)),
    .cancel_all(pre_all), .cancel_one(pre_one), .cancel_bank(ba),
    .pend(pend), .pend_bank(pend_bank), .close_now(close_now)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    logic opn, cls;
    assign opn = accept && is_act && ba == BANK_W'(gi);
    assign cls = pre_all || (pre_one && ba == BANK_W'(gi))
              || (close_now && pend_bank == BANK_W'(gi));
    ddrcmd_bank #(.ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .open_req(opn), .close_req(cls),
      .row_in(addr[ROW_W-1:0]), .is_open(bank_open[gi]),
      .row_q(bank_rows[gi*ROW_W +: ROW_W])
    );
  end

  ddrcmd_power u_pwr (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .ref_seen(!cs_n && pin_cmd == CMD_REF), .state(pwr)
  );
  assign pwr_state = pwr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;
      proto_err <= 1'b0;
      mode_bl   <= 3'd1;
      mode_cl   <= 3'd2;
    end else begin
      cmd_valid <= accept;
      proto_err <= err;
      cmd_code  <= accept ? cur : CMD_NOP;
      cmd_bank  <= '0;
      cmd_addr  <= '0;
      cmd_ap    <= 1'b0;
      if (accept) begin
        case (cur)
          CMD_ACT: begin
            cmd_bank <= ba;
            cmd_addr <= ADDR_W'(addr[ROW_W-1:0]);
          end
          CMD_RD, CMD_WR: begin
            cmd_bank <= ba;
            cmd_addr <= ADDR_W'(addr[COL_W-1:0]);
            cmd_ap   <= addr[AP_BIT];
          end
          CMD_PRE: begin
            cmd_bank <= addr[AP_BIT] ? '0 : ba;
            cmd_ap   <= addr[AP_BIT];
          end
          CMD_MRS: cmd_addr <= addr;
          default: ;
        endcase
      end
      if (accept && is_mrs) begin
        mode_bl <= addr[BL_LSB +: 3];
        mode_cl <= addr[CL_LSB +: 3];
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk
  import ddrcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 9,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_code,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [ADDR_W-1:0]    cmd_addr,
  input logic                 cmd_ap,
  input logic [1:0]           pwr_state,
  input logic [NUM_BANKS-1:0] bank_open
);
  // R2
  strobe_not_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code != CMD_NOP);
  // R4
  act_opens_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_ACT) |-> bank_open[cmd_bank]);
  // R5
  col_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == CMD_RD || cmd_code == CMD_WR)) |-> cmd_addr[ADDR_W-1:COL_W] == '0);
  // R7
  pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CMD_PRE && cmd_ap) |-> (bank_open == '0 && cmd_bank == '0));
  // R11
  no_cmd_in_low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != PWR_ACTIVE) |-> !cmd_valid);
  // R11
  pwr_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
  .pwr_state(pwr_state), .bank_open(bank_open)
);

// File: tb/ddr_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_tb_top;
  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000, P_BST = 3'b110;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic cmd_valid, cmd_ap, proto_err;
  logic [2:0] cmd_code, mode_bl, mode_cl;
  logic [1:0] cmd_bank, pwr_state;
  logic [11:0] cmd_addr;
  logic [3:0] bank_open;
  logic [47:0] bank_rows;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .proto_err(proto_err),
    .pwr_state(pwr_state), .bank_open(bank_open), .bank_rows(bank_rows),
    .mode_bl(mode_bl), .mode_cl(mode_cl)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, return just after the next rising edge
  task automatic drive(input logic k, input logic cs, input logic [2:0] pins,
                       input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] pins, input logic [1:0] b, input logic [11:0] a);
    drive(1'b1, 1'b0, pins, b, a);
  endtask

  task automatic nop();
    drive(1'b1, 1'b1, P_NOP, 2'd0, 12'd0);
  endtask

  task automatic t_reset();
    chk("R1 bank_open", bank_open, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 pwr_state", pwr_state, 0);
    chk("R1 mode_bl", mode_bl, 1);
    chk("R1 mode_cl", mode_cl, 2);
  endtask

  task automatic t_activate();
    cmd(P_ACT, 2'd2, 12'hABC);
    chk("R2 valid", cmd_valid, 1);
    chk("R2 code act", cmd_code, 1);
    chk("R4 bank", cmd_bank, 2);
    chk("R4 addr", cmd_addr, 12'hABC);
    chk("R4 open", bank_open, 4'b0100);
    chk("R4 row", bank_rows[24 +: 12], 12'hABC);
    nop();
    chk("R2 one cycle", cmd_valid, 0);
    cmd(P_BST, 2'd2, 12'h000);
    chk("R2 110 ignored", cmd_valid, 0);
  endtask

  task automatic t_readwrite();
    cmd(P_RD, 2'd2, 12'h9F3);
    chk("R2 code rd", cmd_code, 2);
    chk("R5 col", cmd_addr, 12'h1F3);
    chk("R5 ap", cmd_ap, 0);
    cmd(P_WR, 2'd2, 12'h05A);
    chk("R2 code wr", cmd_code, 3);
    chk("R5 wr col", cmd_addr, 12'h05A);
    nop(); nop(); nop();
    chk("R5 stays open", bank_open, 4'b0100);
  endtask

  task automatic t_errors();
    cmd(P_RD, 2'd0, 12'h010);
    chk("R8 err rd closed", proto_err, 1);
    chk("R8 no valid", cmd_valid, 0);
    chk("R8 state", bank_open, 4'b0100);
    nop();
    chk("R8 one cycle", proto_err, 0);
    cmd(P_ACT, 2'd2, 12'h123);
    chk("R8 err act open", proto_err, 1);
    chk("R8 row kept", bank_rows[24 +: 12], 12'hABC);
  endtask

  task automatic t_precharge();
    cmd(P_ACT, 2'd0, 12'h111);
    cmd(P_ACT, 2'd1, 12'h222);
    chk("R4 three open", bank_open, 4'b0111);
    cmd(P_PRE, 2'd1, 12'h000);
    chk("R6 single", bank_open, 4'b0101);
    chk("R2 code pre", cmd_code, 4);
    chk("R6 ap", cmd_ap, 0);
    chk("R6 bank", cmd_bank, 1);
    cmd(P_PRE, 2'd3, 12'h400);
    chk("R7 all closed", bank_open, 0);
    chk("R7 bank ignored", cmd_bank, 0);
    chk("R7 ap", cmd_ap, 1);
  endtask

  task automatic t_autopre();
    cmd(P_ACT, 2'd3, 12'h333);
    cmd(P_RD, 2'd3, 12'h410);
    chk("R9 bl2 open at e0", bank_open[3], 1);
    chk("R5 ap flag", cmd_ap, 1);
    nop();
    chk("R9 bl2 closed at e1", bank_open[3], 0);
    cmd(P_MRS, 2'd0, 12'h032);
    chk("R2 code mrs", cmd_code, 6);
    chk("R9 bl field", mode_bl, 2);
    chk("R9 cl field", mode_cl, 3);
    cmd(P_ACT, 2'd3, 12'h333);
    cmd(P_WR, 2'd3, 12'h400);
    drive(1'b1, 1'b1, P_ACT, 2'd0, 12'h055);
    chk("R3 cs high ignored", cmd_valid, 0);
    chk("R3 bank0 closed", bank_open[0], 0);
    chk("R9 bl4 open at e1", bank_open[3], 1);
    drive(1'b1, 1'b1, P_NOP, 2'd0, 12'h000);
    chk("R3 close completes at e2", bank_open[3], 0);
    cmd(P_MRS, 2'd0, 12'h023);
    cmd(P_ACT, 2'd3, 12'h333);
    cmd(P_RD, 2'd3, 12'h400);
    nop(); nop(); nop();
    chk("R9 bl8 open at e3", bank_open[3], 1);
    nop();
    chk("R9 bl8 closed at e4", bank_open[3], 0);
    cmd(P_MRS, 2'd0, 12'h025);
    chk("R9 raw code", mode_bl, 5);
    cmd(P_ACT, 2'd3, 12'h333);
    cmd(P_RD, 2'd3, 12'h400);
    nop();
    chk("R9 odd code one cycle", bank_open[3], 0);
  endtask

  task automatic t_ap_cut();
    cmd(P_MRS, 2'd0, 12'h023);
    cmd(P_ACT, 2'd0, 12'h001);
    cmd(P_ACT, 2'd1, 12'h002);
    cmd(P_RD, 2'd0, 12'h400);
    cmd(P_RD, 2'd0, 12'h000);
    chk("R10 pending bank err", proto_err, 1);
    chk("R10 still open", bank_open[0], 1);
    cmd(P_RD, 2'd1, 12'h000);
    chk("R10 accepted", cmd_valid, 1);
    chk("R10 cut closes", bank_open[1:0], 2'b10);
    nop(); nop(); nop(); nop();
    chk("R10 other stays open", bank_open[1], 1);
  endtask

  task automatic t_power();
    cmd(P_PRE, 2'd0, 12'h400);
    drive(1'b0, 1'b1, P_NOP, 2'd0, 12'h000);
    chk("R11 power-down", pwr_state, 1);
    drive(1'b0, 1'b0, P_ACT, 2'd2, 12'h777);
    chk("R11 no decode", cmd_valid, 0);
    chk("R11 bank untouched", bank_open, 0);
    drive(1'b0, 1'b0, P_REF, 2'd0, 12'h000);
    chk("R11 hold pd", pwr_state, 1);
    drive(1'b1, 1'b0, P_ACT, 2'd2, 12'h777);
    chk("R11 exit", pwr_state, 0);
    chk("R11 exit decodes", bank_open, 4'b0100);
    drive(1'b0, 1'b0, P_REF, 2'd0, 12'h000);
    chk("R11 self-refresh", pwr_state, 2);
    chk("R11 sr no strobe", cmd_valid, 0);
    drive(1'b0, 1'b1, P_NOP, 2'd0, 12'h000);
    chk("R11 sr hold", pwr_state, 2);
    drive(1'b1, 1'b1, P_NOP, 2'd0, 12'h000);
    chk("R11 sr exit", pwr_state, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_activate();
    t_readwrite();
    t_errors();
    t_precharge();
    t_autopre();
    t_ap_cut();
    t_power();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule